// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a register-mapped watchdog. Software programs a control word, a 16-bit reload value and the live 16-bit down-counter over a small register bus. The counter moves one step per tick. The tick comes from an 8-bit prescaler followed by a power-of-two divider that can be set to 16, 32, 64 or 128.

Software keeps the system alive by writing the counter. If the counter is found at zero on a tick, the timer has expired. It then reloads from the reload register. Depending on the control bits, it also latches an interrupt, starts a reset-request pulse of fixed length, or does both. A write of any value to the clear address removes a latched interrupt.

Counting needs two enables: the control enable bit and an external counter-enable input. When the debug mask bit is set, a high debug-acknowledge input holds both outputs low.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset the control register reads 0, the reload register reads 0x8000, the count reads 0x8000, and `irq` and `rst_req` are low.
- R2: Register offsets are 0x0 control, 0x4 reload, 0x8 count and 0xC interrupt clear. Read data appears on `bus_rdata` one cycle after `bus_re`. The clear offset reads as 0. Control fields are: bit 0 reset enable, bit 2 interrupt enable, bits 4:3 divider select, bit 5 run, bits 15:8 prescaler, bit 16 debug mask. All other control bits read 0.
- R3: One tick lasts (prescaler+1)·2^(4+select) clock cycles. Select values 0, 1, 2 and 3 give /16, /32, /64 and /128.
- R4: A write to the count offset loads the value in the next cycle and restarts the prescaler and the divider. With the timer running, a load of C makes the expiry edge fall exactly (C+1)·tick cycles after the write edge.
- R5: On expiry the count is reloaded from the reload register.
- R6: On expiry, `irq` rises only if bit 2 is set. It stays high until a write of any value to offset 0xC. With bit 2 clear, no interrupt is latched.
- R7: On expiry with bit 0 set, `rst_req` is high for exactly RST_PULSE (default 8) consecutive cycles.
- R8: The count changes only on a tick, and ticks occur only while control bit 5 and `cnt_en_in` are both high. Otherwise the count and the prescaler state hold.
- R9: While control bit 16 is set and `dbg_ack` is high, `irq` and `rst_req` are low. A latched interrupt stays latched and shows again once `dbg_ack` falls.
- R10: The count is 16 bits wide. A count write keeps only `bus_wdata[15:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| dbg_ack | input | 1 | Debug acknowledge |
| cnt_en_in | input | 1 | External counter enable |
| irq | output | 1 | Interrupt, level |
| rst_req | output | 1 | Reset request pulse |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data is due one edge after `bus_re`. The bench drives on falling edges and samples on the next falling edge, one cycle on. Expiry is due exactly (C+1)·tick edges after the count write. For each vector, the bench samples `irq` low on the falling edge before that edge and high on the one after it. The reset pulse is due on the same edge as the interrupt, and its width is counted in whole cycles. The debug mask acts combinationally on the registered outputs, so its effect is checked in the same cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W       = 16;
    localparam int PRE_W       = 8;
    localparam int DIV_MIN_LOG = 4;
    localparam int DIV_W       = DIV_MIN_LOG + 3;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_RELOAD = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_CLEAR  = 4'hC;

    localparam logic [CNT_W-1:0] CNT_RESET = 16'h8000;

    typedef enum logic [1:0] {
        DIV_BY16  = 2'd0,
        DIV_BY32  = 2'd1,
        DIV_BY64  = 2'd2,
        DIV_BY128 = 2'd3
    } div_sel_e;

    typedef struct packed {
        logic             dbg_mask;
        logic [PRE_W-1:0] pre;
        logic             run;
        div_sel_e         div_sel;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.rst_en   = w[0];
        c.irq_en   = w[2];
        c.div_sel  = div_sel_e'(w[4:3]);
        c.run      = w[5];
        c.pre      = w[15:8];
        c.dbg_mask = w[16];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w       = '0;
        w[0]    = c.rst_en;
        w[2]    = c.irq_en;
        w[4:3]  = c.div_sel;
        w[5]    = c.run;
        w[15:8] = c.pre;
        w[16]   = c.dbg_mask;
        return w;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    input  logic [CNT_W-1:0]  count_val,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              cnt_wr,
    output logic              clr_wr
);
    logic [DATA_W-1:0] rd_mux;

    assign cnt_wr = we && (addr == OFF_COUNT);
    assign clr_wr = we && (addr == OFF_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= CNT_RESET;
        end else if (we) begin
            if (addr == OFF_CTRL)   ctrl   <= ctrl_unpack(wdata);
            if (addr == OFF_RELOAD) reload <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        unique case (addr)
            OFF_CTRL:   rd_mux = ctrl_pack(ctrl);
            OFF_RELOAD: rd_mux = DATA_W'(reload);
            OFF_COUNT:  rd_mux = DATA_W'(count_val);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= rd_mux;
    end
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre,
    input  div_sel_e         div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] need;
    logic             pre_tick;

    always_comb begin
        for (int i = 0; i < DIV_W; i++)
            need[i] = (i < DIV_MIN_LOG + int'(div_sel));
    end

    assign pre_tick = run && (pre_cnt == pre);
    assign tick     = pre_tick && ((div_cnt & need) == need);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
            div_cnt <= div_cnt + 1'b1;
        end else if (run) begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    assign expire = tick && !load && (count == '0);

    always_ff @(posedge clk) begin
        if (rst)         count <= CNT_RESET;
        else if (load)   count <= load_val;
        else if (expire) count <= reload;
        else if (tick)   count <= count - 1'b1;
    end
endmodule

// File: rtl/wdt_out.sv
module wdt_out #(
    parameter int RST_PULSE = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic irq_en,
    input  logic rst_en,
    input  logic clr,
    input  logic hold_off,
    output logic irq_pend,
    output logic irq,
    output logic rst_req
);
    localparam int PW = $clog2(RST_PULSE + 1);
    localparam logic [PW-1:0] PULSE_LEN = PW'(RST_PULSE);

    logic [PW-1:0] pulse_left;

    always_ff @(posedge clk) begin
        if (rst)                    irq_pend <= 1'b0;
        else if (expire && irq_en)  irq_pend <= 1'b1;
        else if (clr)               irq_pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                     pulse_left <= '0;
        else if (expire && rst_en)   pulse_left <= PULSE_LEN;
        else if (pulse_left != '0)   pulse_left <= pulse_left - 1'b1;
    end

    assign irq     = irq_pend && !hold_off;
    assign rst_req = (pulse_left != '0) && !hold_off;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int RST_PULSE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_ack,
    input  logic              cnt_en_in,
    output logic              irq,
    output logic              rst_req
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic             cnt_wr;
    logic             clr_wr;
    logic             tick;
    logic             expire;
    logic             irq_pend;
    logic             counting;

    assign counting = ctrl_q.run && cnt_en_in;

    wdt_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .re(bus_re), .count_val(count_q), .rdata(bus_rdata),
        .ctrl(ctrl_q), .reload(reload_q), .cnt_wr(cnt_wr), .clr_wr(clr_wr)
    );

    wdt_tick u_tick (
        .clk(clk), .rst(rst), .run(counting), .restart(cnt_wr),
        .pre(ctrl_q.pre), .div_sel(ctrl_q.div_sel), .tick(tick)
    );

    wdt_count u_count (
        .clk(clk), .rst(rst), .load(cnt_wr), .load_val(bus_wdata[CNT_W-1:0]),
        .tick(tick), .reload(reload_q), .count(count_q), .expire(expire)
    );

    wdt_out #(.RST_PULSE(RST_PULSE)) u_out (
        .clk(clk), .rst(rst), .expire(expire), .irq_en(ctrl_q.irq_en),
        .rst_en(ctrl_q.rst_en), .clr(clr_wr),
        .hold_off(ctrl_q.dbg_mask && dbg_ack),
        .irq_pend(irq_pend), .irq(irq), .rst_req(rst_req)
    );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int RST_PULSE = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              dbg_ack,
    input logic              cnt_en_in,
    input logic              run_bit,
    input logic              mask_bit,
    input logic [CNT_W-1:0]  count_q,
    input logic              irq_pend,
    input logic              irq,
    input logic              rst_req
);
    logic kick;
    logic clr;
    int   hi_len;

    assign kick = bus_we && (bus_addr == OFF_COUNT);
    assign clr  = bus_we && (bus_addr == OFF_CLEAR);

    always_ff @(posedge clk) begin
        if (rst || !rst_req) hi_len <= 0;
        else                 hi_len <= hi_len + 1;
    end

    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (count_q == CNT_RESET) && !irq && !rst_req);

    p_kick_load_r4: assert property (@(posedge clk) disable iff (rst)
        kick |=> (count_q == $past(bus_wdata[CNT_W-1:0])));

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && !clr) |=> irq_pend);

    p_pulse_len_r7: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (hi_len < RST_PULSE));

    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (!(run_bit && cnt_en_in) && !kick) |=> $stable(count_q));

    p_dbg_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (mask_bit && dbg_ack) |-> (!irq && !rst_req));
endmodule

bind wdog_timer wdt_chk #(.RST_PULSE(RST_PULSE)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .dbg_ack(dbg_ack), .cnt_en_in(cnt_en_in),
    .run_bit(ctrl_q.run), .mask_bit(ctrl_q.dbg_mask), .count_q(count_q),
    .irq_pend(irq_pend), .irq(irq), .rst_req(rst_req)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
    localparam int PULSE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        dbg_ack = 1'b0;
    logic        cnt_en_in = 1'b1;
    logic        irq;
    logic        rst_req;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wdog_timer #(.RST_PULSE(PULSE)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .dbg_ack(dbg_ack), .cnt_en_in(cnt_en_in), .irq(irq), .rst_req(rst_req)
    );

    // {prescaler, select, load value, expiry cycles = (C+1)*(pre+1)*2^(4+sel)}
    localparam logic [47:0] VEC [6] = '{
        {8'd0, 8'd0, 16'd3, 16'd64},
        {8'd1, 8'd0, 16'd2, 16'd96},
        {8'd0, 8'd1, 16'd1, 16'd64},
        {8'd2, 8'd2, 16'd0, 16'd192},
        {8'd0, 8'd3, 16'd1, 16'd256},
        {8'd3, 8'd0, 16'd4, 16'd320}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            bad  = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired: actual=hang expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] r;
        int hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h0, r); check("R1 ctrl", r, 32'h0);
        rd(4'h4, r); check("R1 reload", r, 32'h8000);
        rd(4'h8, r); check("R1 count", r, 32'h8000);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R2 control field readback and clear offset read
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, r); check("R2 ctrl fields", r, 32'h0001_FF3D);
        wr(4'h0, 32'h0);
        rd(4'hC, r); check("R2 clear reads zero", r, 32'h0);

        // R10 16-bit count write
        wr(4'h8, 32'h0001_2345);
        rd(4'h8, r); check("R10 count width", r, 32'h2345);

        // R3 R4 R5 R6 vector table
        wr(4'h4, 32'h3);
        for (int i = 0; i < 6; i++) begin
            logic [7:0]  pre;
            logic [7:0]  sel;
            logic [15:0] ld;
            logic [15:0] cyc_exp;
            {pre, sel, ld, cyc_exp} = VEC[i];
            wr(4'h0, {16'h0, pre, 3'b001, sel[1:0], 3'b100});
            wr(4'h8, {16'h0, ld});
            repeat (int'(cyc_exp) - 1) @(negedge clk);
            check("R3 R4 irq before expiry", {31'b0, irq}, 32'h0);
            @(negedge clk);
            check("R3 R4 irq at expiry", {31'b0, irq}, 32'h1);
            rd(4'h8, r); check("R5 reload after expiry", r, 32'h3);
            wr(4'hC, 32'h0);
            check("R6 clear by any value", {31'b0, irq}, 32'h0);
            wr(4'h0, 32'h0);
        end

        // R8 freeze: run bit set, external enable low
        cnt_en_in = 1'b0;
        wr(4'h0, 32'h24);
        wr(4'h8, 32'h5);
        repeat (200) @(negedge clk);
        rd(4'h8, r); check("R8 frozen by cnt_en_in", r, 32'h5);
        cnt_en_in = 1'b1;
        wr(4'h0, 32'h04);
        repeat (200) @(negedge clk);
        rd(4'h8, r); check("R8 frozen by run bit", r, 32'h5);
        check("R8 no irq while frozen", {31'b0, irq}, 32'h0);

        // R6 no interrupt when disabled
        wr(4'h0, 32'h20);
        wr(4'h8, 32'h0);
        repeat (20) @(negedge clk);
        check("R6 irq disabled", {31'b0, irq}, 32'h0);
        wr(4'h0, 32'h0);

        // R7 reset pulse width
        wr(4'h0, 32'h21);
        wr(4'h8, 32'h0);
        repeat (15) @(negedge clk);
        check("R7 rst_req before expiry", {31'b0, rst_req}, 32'h0);
        @(negedge clk);
        check("R7 rst_req at expiry", {31'b0, rst_req}, 32'h1);
        hi = 1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (rst_req) hi++;
            else break;
        end
        check("R7 pulse length", hi, PULSE);
        wr(4'h0, 32'h0);

        // R9 debug mask
        dbg_ack = 1'b1;
        wr(4'h0, 32'h0001_0025);
        wr(4'h8, 32'h0);
        repeat (17) @(negedge clk);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        check("R9 rst_req masked", {31'b0, rst_req}, 32'h0);
        dbg_ack = 1'b0;
        #1;
        check("R9 irq released", {31'b0, irq}, 32'h1);
        check("R9 rst_req released", {31'b0, rst_req}, 32'h1);
        wr(4'h0, 32'h0);
        wr(4'hC, 32'hDEAD_BEEF);
        check("R6 clear after mask", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule